// File: doc/BRIEF.md
# Three-Wire Reader Command Interface

This block is the host-facing control port of a contactless reader front end. A host drives a serial clock and a data line; the block answers on a separate output line that idles high, as an open-drain line with pull-up does. After a start condition the block collects a command of three or eight bits and acts on it. Eight-bit commands can write a 4-bit nibble into one of four configuration pages, set a 6-bit sampling time, store a 4-bit write pulse width N, or request an 8-bit read-back. Three-bit short forms switch the block into a receive mode or a transmit mode at once.

Both serial inputs are asynchronous to the system clock. Each passes through a parameterised synchroniser and then an edge detector. A phase value and two status flags (antenna failure and amplitude comparison) come from outside and are captured into read-back responses at the moment the request is decoded. All configuration state is visible on a flat output bus, so the analog side can use it directly.

Top module: `rdr_serial_ctrl`

## Requirements
- R1: After reset, the page bus `cfg_pages` is 16'h0008: every bit is zero except bit 3 of page 0, the high-gain select. Sampling time and N are zero, both mode outputs are low, and `ser_dout` is high.
- R2: A command is framed by a rising edge on `ser_din` while `ser_clk` is high. Serial clock edges seen before any start condition have no effect. A new start condition discards a partly received command and restarts the bit count.
- R3: Command bits are sampled on rising edges of `ser_clk`, most significant bit first.
- R4: When the first three bits are 111, `mode_read` rises right after the third bit. It falls on the next rising edge of `ser_clk`.
- R5: When the first three bits are 110, `mode_write` rises right after the third bit, and the stored N is left unchanged. `mode_write` falls on the next rising edge of `ser_clk`.
- R6: The byte 0001NNNN stores NNNN as N (shown on `wr_pulse_n`) and raises `mode_write`. It ends like R5.
- R7: The byte 10DDDDDD loads DDDDDD into `samp_time`. The byte 01PPDDDD loads DDDD into page PP. Page p occupies `cfg_pages[4p+3:4p]`.
- R8: The byte 00001000 returns {2'b00, `phase_i`}. The byte 00000010 returns {2'b00, sampling time}. A response is presented on `ser_dout` MSB first, one bit for each of the eight `ser_clk` high phases that follow the command, and changes only after falling edges.
- R9: The byte 000001PP returns page PP in the low nibble. The high nibble is N for pages 0 and 1, and {0, 0, `stat_ampcmp`, `stat_antfail`} for pages 2 and 3.
- R10: Any other byte, such as 00000011, changes no state and produces no response.
- R11: `ser_dout` is high whenever no response is being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Host serial clock, asynchronous |
| ser_din | input | 1 | Host serial data in, asynchronous |
| ser_dout | output | 1 | Serial response, high when released |
| phase_i | input | 6 | Measured antenna phase |
| stat_antfail | input | 1 | Antenna failure flag |
| stat_ampcmp | input | 1 | Amplitude comparison flag |
| mode_read | output | 1 | Receive mode active |
| mode_write | output | 1 | Transmit mode active |
| wr_pulse_n | output | 4 | Stored write pulse width N |
| samp_time | output | 6 | Sampling time register |
| cfg_pages | output | 16 | Four configuration nibbles, page 0 lowest |

## Verification
Several behaviours are checked on every cycle by assertions:
- A start condition resets the receiver.
- Clock activity without a start leaves the block idle.
- Either mode ends on a rising clock edge.
- A page or sampling-time write lands exactly where it was aimed.
- Pages stay untouched when no write strobe is present.
- A response word moves only on falling clock edges.

Only the bench's scenarios can show the rest: that the decoded values are correct, that the packed read-back nibbles are right (N, or live status), and that the stored N survives a short-form transmit command.

// File: rtl/rdr_ser_pkg.sv
package rdr_ser_pkg;
  localparam int CMD_W  = 8;
  localparam int NIB_W  = 4;
  localparam int STM_W  = 6;
  localparam int NPAGES = 4;
  localparam int PSEL_W = $clog2(NPAGES);
  localparam int CNT_W  = $clog2(CMD_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_RESP,
    ST_RTAG,
    ST_WTAG
  } ser_state_t;
endpackage

// File: rtl/rdr_ser_sync.sv
module rdr_ser_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_a,
  input  logic sdi_a,
  output logic sdi_o,
  output logic sck_rise,
  output logic sck_fall,
  output logic start_o
);
  logic [STAGES-1:0] sck_ch, sdi_ch;
  logic sck_d, sdi_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_ch <= '0;
      sdi_ch <= '0;
      sck_d  <= 1'b0;
      sdi_d  <= 1'b0;
    end else begin
      sck_ch[0] <= sck_a;
      sdi_ch[0] <= sdi_a;
      sck_d     <= sck_ch[STAGES-1];
      sdi_d     <= sdi_ch[STAGES-1];
    end
  end

  // remaining synchroniser stages
  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        sck_ch[g] <= 1'b0;
        sdi_ch[g] <= 1'b0;
      end else begin
        sck_ch[g] <= sck_ch[g-1];
        sdi_ch[g] <= sdi_ch[g-1];
      end
    end
  end

  assign sdi_o    = sdi_ch[STAGES-1];
  assign sck_rise = sck_ch[STAGES-1] & ~sck_d;
  assign sck_fall = ~sck_ch[STAGES-1] & sck_d;
  // data edge while the clock is steadily high frames a command
  assign start_o  = sck_ch[STAGES-1] & sck_d & sdi_ch[STAGES-1] & ~sdi_d;
endmodule

// File: rtl/rdr_ser_regs.sv
module rdr_ser_regs
  import rdr_ser_pkg::*;
#(
  parameter logic [NPAGES*NIB_W-1:0] PAGE_RST = 16'h0008
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pg_we,
  input  logic [PSEL_W-1:0]       pg_sel,
  input  logic [NIB_W-1:0]        pg_wd,
  input  logic                    st_we,
  input  logic [STM_W-1:0]        st_wd,
  input  logic                    n_we,
  input  logic [NIB_W-1:0]        n_wd,
  input  logic [PSEL_W-1:0]       rd_sel,
  output logic [NIB_W-1:0]        rd_nib,
  output logic [STM_W-1:0]        samp_q,
  output logic [NIB_W-1:0]        n_q,
  output logic [NPAGES*NIB_W-1:0] pages_flat
);
  logic [NIB_W-1:0] pg_q [NPAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPAGES; i++) pg_q[i] <= PAGE_RST[i*NIB_W +: NIB_W];
      samp_q <= '0;
      n_q    <= '0;
    end else begin
      if (pg_we) pg_q[pg_sel] <= pg_wd;
      if (st_we) samp_q <= st_wd;
      if (n_we)  n_q <= n_wd;
    end
  end

  for (genvar g = 0; g < NPAGES; g++) begin : g_flat
    assign pages_flat[g*NIB_W +: NIB_W] = pg_q[g];
  end

  assign rd_nib = pg_q[rd_sel];

  AST_PAGE_WR: assert property (@(posedge clk) disable iff (rst)
    pg_we |=> pg_q[$past(pg_sel)] == $past(pg_wd)); // R7
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pg_we |=> $stable(pages_flat)); // R10
  AST_SAMP_WR: assert property (@(posedge clk) disable iff (rst)
    st_we |=> samp_q == $past(st_wd)); // R7
endmodule

// File: rtl/rdr_ser_fsm.sv
module rdr_ser_fsm
  import rdr_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sdi,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              start,
  input  logic [STM_W-1:0]  phase_i,
  input  logic              antfail,
  input  logic              ampcmp,
  input  logic [NIB_W-1:0]  rd_nib,
  input  logic [STM_W-1:0]  samp_q,
  input  logic [NIB_W-1:0]  n_q,
  output logic [PSEL_W-1:0] rd_sel,
  output logic              pg_we,
  output logic [PSEL_W-1:0] pg_sel,
  output logic [NIB_W-1:0]  pg_wd,
  output logic              st_we,
  output logic [STM_W-1:0]  st_wd,
  output logic              n_we,
  output logic [NIB_W-1:0]  n_wd,
  output logic              mode_read,
  output logic              mode_write,
  output logic              dout
);
  ser_state_t        st_q;
  logic [CNT_W-1:0]  cnt_q, ocnt_q;
  logic [CMD_W-2:0]  sh_q;
  logic [CMD_W-1:0]  obuf_q;
  logic [CMD_W-1:0]  nxt;
  logic              last_bit;

  assign nxt      = {sh_q, sdi};
  assign last_bit = (st_q == ST_CMD) && sck_rise && (cnt_q == CNT_W'(CMD_W-1));

  assign pg_we  = last_bit && (nxt[7:6] == 2'b01);
  assign pg_sel = nxt[5:4];
  assign pg_wd  = nxt[3:0];
  assign st_we  = last_bit && (nxt[7:6] == 2'b10);
  assign st_wd  = nxt[5:0];
  assign n_we   = last_bit && (nxt[7:4] == 4'b0001);
  assign n_wd   = nxt[3:0];
  assign rd_sel = nxt[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      ocnt_q <= '0;
      sh_q   <= '0;
      obuf_q <= '0;
    end else if (start) begin
      st_q  <= ST_CMD;
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      case (st_q)
        ST_CMD: if (sck_rise) begin
          sh_q  <= nxt[CMD_W-2:0];
          cnt_q <= cnt_q + CNT_W'(1);
          ocnt_q <= '0;
          if (cnt_q == CNT_W'(2) && nxt[2:1] == 2'b11) begin
            st_q <= nxt[0] ? ST_RTAG : ST_WTAG;
          end else if (cnt_q == CNT_W'(CMD_W-1)) begin
            casez (nxt)
              8'b0001????: st_q <= ST_WTAG;
              8'b00001000: begin st_q <= ST_RESP; obuf_q <= {2'b00, phase_i}; end
              8'b00000010: begin st_q <= ST_RESP; obuf_q <= {2'b00, samp_q}; end
              8'b000001??: begin
                st_q   <= ST_RESP;
                obuf_q <= {(nxt[1] ? {2'b00, ampcmp, antfail} : n_q), rd_nib};
              end
              default:     st_q <= ST_IDLE;
            endcase
          end
        end
        ST_RESP: begin
          if (sck_rise) ocnt_q <= ocnt_q + CNT_W'(1);
          else if (sck_fall && ocnt_q != '0) begin
            if (ocnt_q == CNT_W'(CMD_W)) st_q <= ST_IDLE;
            else obuf_q <= {obuf_q[CMD_W-2:0], 1'b0};
          end
        end
        ST_RTAG, ST_WTAG: if (sck_rise) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mode_read  = (st_q == ST_RTAG);
  assign mode_write = (st_q == ST_WTAG);
  assign dout       = (st_q == ST_RESP) ? obuf_q[CMD_W-1] : 1'b1;

  AST_START_ABORT: assert property (@(posedge clk) disable iff (rst)
    start |=> (st_q == ST_CMD && cnt_q == '0)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && !start) |=> st_q == ST_IDLE); // R2
  AST_MODE_END: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_RTAG || st_q == ST_WTAG) && sck_rise && !start) |=> st_q == ST_IDLE); // R4
  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RESP && !sck_fall && !start) |=> $stable(obuf_q)); // R8
endmodule

// File: rtl/rdr_serial_ctrl.sv
module rdr_serial_ctrl
  import rdr_ser_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [NPAGES*NIB_W-1:0] PAGE_RST = 16'h0008
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ser_clk,
  input  logic                    ser_din,
  output logic                    ser_dout,
  input  logic [STM_W-1:0]        phase_i,
  input  logic                    stat_antfail,
  input  logic                    stat_ampcmp,
  output logic                    mode_read,
  output logic                    mode_write,
  output logic [NIB_W-1:0]        wr_pulse_n,
  output logic [STM_W-1:0]        samp_time,
  output logic [NPAGES*NIB_W-1:0] cfg_pages
);
  logic sdi, sck_rise, sck_fall, start;
  logic pg_we, st_we, n_we;
  logic [PSEL_W-1:0] pg_sel, rd_sel;
  logic [NIB_W-1:0]  pg_wd, n_wd, rd_nib;
  logic [STM_W-1:0]  st_wd;

  rdr_ser_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .sck_a(ser_clk), .sdi_a(ser_din),
    .sdi_o(sdi), .sck_rise(sck_rise), .sck_fall(sck_fall), .start_o(start)
  );

  rdr_ser_fsm fsm_i (
    .clk(clk), .rst(rst), .sdi(sdi), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .start(start), .phase_i(phase_i), .antfail(stat_antfail), .ampcmp(stat_ampcmp),
    .rd_nib(rd_nib), .samp_q(samp_time), .n_q(wr_pulse_n), .rd_sel(rd_sel),
    .pg_we(pg_we), .pg_sel(pg_sel), .pg_wd(pg_wd), .st_we(st_we), .st_wd(st_wd),
    .n_we(n_we), .n_wd(n_wd), .mode_read(mode_read), .mode_write(mode_write),
    .dout(ser_dout)
  );

  rdr_ser_regs #(.PAGE_RST(PAGE_RST)) regs_i (
    .clk(clk), .rst(rst), .pg_we(pg_we), .pg_sel(pg_sel), .pg_wd(pg_wd),
    .st_we(st_we), .st_wd(st_wd), .n_we(n_we), .n_wd(n_wd), .rd_sel(rd_sel),
    .rd_nib(rd_nib), .samp_q(samp_time), .n_q(wr_pulse_n), .pages_flat(cfg_pages)
  );
endmodule

// File: tb/rdr_serial_ctrl_tb_top.sv
module rdr_serial_ctrl_tb_top;
  localparam int H = 10;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_din = 1'b0;
  logic ser_dout, mode_read, mode_write;
  logic [5:0] phase_i = 6'h15;
  logic stat_antfail = 1'b1, stat_ampcmp = 1'b0;
  logic [3:0] wr_pulse_n;
  logic [5:0] samp_time;
  logic [15:0] cfg_pages;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rdr_serial_ctrl dut_i (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_din(ser_din), .ser_dout(ser_dout),
    .phase_i(phase_i), .stat_antfail(stat_antfail), .stat_ampcmp(stat_ampcmp),
    .mode_read(mode_read), .mode_write(mode_write), .wr_pulse_n(wr_pulse_n),
    .samp_time(samp_time), .cfg_pages(cfg_pages)
  );

  // {kind, command, expected}: kind 0 no reply, 1 reply, 2 write-tag with N
  localparam logic [17:0] VECS [14] = '{
    {2'd0, 8'b0100_0101, 8'h00}, {2'd1, 8'b0000_0100, 8'h05},
    {2'd0, 8'b0101_1010, 8'h00}, {2'd2, 8'b0001_0111, 8'h00},
    {2'd1, 8'b0000_0101, 8'h7A}, {2'd0, 8'b1010_1101, 8'h00},
    {2'd1, 8'b0000_0010, 8'h2D}, {2'd0, 8'b0110_0011, 8'h00},
    {2'd1, 8'b0000_0110, 8'h13}, {2'd0, 8'b0111_1100, 8'h00},
    {2'd1, 8'b0000_0111, 8'h1C}, {2'd1, 8'b0000_1000, 8'h15},
    {2'd0, 8'b0000_0011, 8'h00}, {2'd1, 8'b0000_0100, 8'h75}
  };

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start_cond();
    ser_din = 1'b0; wt(H);
    ser_clk = 1'b1; wt(H);
    ser_din = 1'b1; wt(H);
    ser_clk = 1'b0; wt(H);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_din = v[i]; wt(H);
      ser_clk = 1'b1; wt(H);
      ser_clk = 1'b0; wt(H);
    end
  endtask

  task automatic read_resp(output logic [7:0] r);
    for (int k = 7; k >= 0; k--) begin
      ser_clk = 1'b1; wt(H);
      r[k] = ser_dout;
      ser_clk = 1'b0; wt(H);
    end
  endtask

  task automatic clk_pulse();
    ser_clk = 1'b1; wt(H);
    ser_clk = 1'b0; wt(H);
  endtask

  initial begin
    logic [7:0] r;
    wt(5);
    rst = 1'b0;
    wt(2);
    // R1 reset state
    check("R1 pages", cfg_pages, 16'h0008);
    check("R1 samp", samp_time, 6'h0);
    check("R1 n", wr_pulse_n, 4'h0);
    check("R1 modes", {mode_read, mode_write}, 2'b00);
    check("R1 dout", ser_dout, 1'b1);

    for (int v = 0; v < 14; v++) begin
      start_cond();
      send_bits(VECS[v][15:8], 8);
      if (VECS[v][17:16] == 2'd1) begin
        read_resp(r);
        check("R8 R9 response", r, VECS[v][7:0]);
        check("R11 released", ser_dout, 1'b1);
      end else if (VECS[v][17:16] == 2'd2) begin
        check("R6 write mode", mode_write, 1'b1);
        clk_pulse();
        check("R6 write end", mode_write, 1'b0);
      end
    end
    check("R7 pages", cfg_pages, 16'hC3A5);
    check("R7 samp", samp_time, 6'h2D);
    check("R6 n", wr_pulse_n, 4'h7);

    // R2: clock edges without a start have no effect
    send_bits(8'b0100_1111, 8);
    check("R2 no start", cfg_pages, 16'hC3A5);
    check("R11 idle dout", ser_dout, 1'b1);

    // R2: abort a partial page write with a new start
    start_cond();
    send_bits(8'b0111_1000, 5);
    start_cond();
    send_bits(8'b0000_0111, 8);
    read_resp(r);
    check("R2 abort", r, 8'h1C);
    check("R2 pages kept", cfg_pages, 16'hC3A5);

    // R4 read mode short form
    start_cond();
    send_bits(8'b0000_0111, 3);
    check("R4 enter", {mode_read, mode_write}, 2'b10);
    clk_pulse();
    check("R4 exit", mode_read, 1'b0);

    // R5 write mode short form keeps N
    start_cond();
    send_bits(8'b0000_0110, 3);
    check("R5 enter", {mode_read, mode_write}, 2'b01);
    check("R5 n kept", wr_pulse_n, 4'h7);
    clk_pulse();
    check("R5 exit", mode_write, 1'b0);

    // R9 live status in the high nibble, R3 bit order
    stat_ampcmp = 1'b1; stat_antfail = 1'b0;
    start_cond();
    send_bits(8'b0000_0111, 8);
    read_resp(r);
    check("R9 status", r, 8'h2C);

    // R10 unknown code
    start_cond();
    send_bits(8'b0000_0001, 8);
    check("R10 dout", ser_dout, 1'b1);
    check("R10 pages", {cfg_pages, samp_time, wr_pulse_n}, {16'hC3A5, 6'h2D, 4'h7});

    // R1 reset again
    rst = 1'b1; wt(3); rst = 1'b0; wt(2);
    check("R1 re-reset", {cfg_pages, samp_time, wr_pulse_n}, {16'h0008, 6'h0, 4'h0});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule